// File: doc/BRIEF.md
# Fastlock Charge-Pump Current Timer

This block picks which of two programmed charge-pump current codes drives the current DAC while a synthesizer locks. A primary code is used in steady state. A secondary, normally larger, code boosts the loop while it settles after a frequency change. Software requests the boost by writing a CP-gain bit of 1 into the feedback-counter register. The block reads that bit, the fastlock enable bit, the fastlock mode bit and a 4-bit timeout code, and from them produces the active 3-bit current code.

Two exit modes are supported. In the manual mode, the boost lasts until software writes the CP-gain bit back to 0. In the timed mode, a counter advanced by phase-detector strobes ends the boost after a programmable number of comparisons. The block then raises a one-cycle clear strobe, which the register uses to reset the CP-gain bit, so no further write is needed. A power-down input holds the timeout counter in its load state. The register write path and the current DAC lie outside the block.

Top module: `fastlock_cp_timer`

## Requirements
- R1: Out of reset, with the CP-gain bit at 0, `cur_code` equals `set_pri` and `gain_clr` is 0.
- R2: While `fl_en` is 0, `cur_code` equals `set_pri` whatever the CP-gain bit, the mode and the strobes do.
- R3: With `fl_en` at 1, a CP-gain bit of 1 makes `cur_code` equal `set_sec` from the cycle after the `gain_set` write, in both modes, until an exit occurs.
- R4: In manual mode (`fl_mode` = 0), no number of phase-detector strobes ends the boost and `gain_clr` stays 0. Only a software write of 0 to the CP-gain bit returns `cur_code` to `set_pri`.
- R5: In timed mode (`fl_mode` = 1), the boost lasts 3 + 4×`tmo_code` phase-detector strobes after the `gain_set` write. On the clock edge that takes that last strobe, `gain_clr` rises for exactly one cycle and `cur_code` returns to `set_pri` in the same cycle. All earlier strobes leave `set_sec` active.
- R6: The timeout counter advances only on cycles where `pd_tick` is 1. Idle cycles between strobes do not shorten or lengthen the timeout.
- R7: A `gain_set` write while a timed boost is running restarts the count from zero, so a full new timeout follows that write.
- R8: While `pwr_dn` is 1, the timeout counter is held at its load state and strobes are not counted. After `pwr_dn` returns to 0, a full timeout is counted from zero.
- R9: `gain_clr` is never asserted in manual mode or while `fl_en` is 0, and it never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fl_en | input | 1 | Fastlock enable from the function register |
| fl_mode | input | 1 | 0 = manual exit, 1 = timed exit |
| tmo_code | input | 4 | Timeout code; the timeout is 3 + 4×code strobes |
| set_pri | input | 3 | Primary (steady-state) current code |
| set_sec | input | 3 | Secondary (boost) current code |
| gain_bit | input | 1 | Current content of the CP-gain register bit |
| gain_set | input | 1 | One-cycle pulse: CP-gain bit is being written to 1 |
| pd_tick | input | 1 | Phase-detector comparison strobe |
| pwr_dn | input | 1 | Power-down; holds the timeout counter at load state |
| cur_code | output | 3 | Active charge-pump current code |
| gain_clr | output | 1 | One-cycle strobe that clears the CP-gain bit |

## Verification
The timed mode is swept over all 16 timeout codes, with idle gaps of 0, 1 and 2 cycles mixed between strobes. This separates a counter that counts strobes from one that counts cycles, and it exposes any off-by-one between the code and the length. The code mux is tried with all 64 primary/secondary pairs, once with enable low and once with enable high, so a swapped or stuck selection cannot hide behind a lucky pair. A long manual-mode run confirms that no timeout exists there. Two further runs check the exits that do not involve the timer: a rewrite part-way through a timeout, and a power-down part-way through a timeout. Each must yield a full fresh timeout afterwards, which tells a true restart apart from a pause.

// File: rtl/flk_pkg.sv
// Package: shared types for the fastlock current timer.
// Assumes: mode bit encoding 0 = manual exit, 1 = timed exit.
package flk_pkg;
    typedef enum logic {
        MODE_MANUAL = 1'b0,
        MODE_TIMED  = 1'b1
    } flk_mode_e;
endpackage

// File: rtl/flk_timer.sv
// Timeout counter for timed fastlock exit.
// Counts phase-detector strobes while the timed boost is live and fires a
// one-cycle expiry after BASE + STEP*tc strobes.
// Assumes: arm is a one-cycle pulse that coincides with the CP-gain write.
module flk_timer #(
    parameter int TC_W = 4,
    parameter int BASE = 3,
    parameter int STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            arm,
    input  logic            hold,
    input  logic            tick,
    input  logic [TC_W-1:0] tc,
    output logic            expire_o,
    output logic            done_o
);
    localparam int MAXLIM = BASE + STEP * ((1 << TC_W) - 1);
    localparam int CNT_W  = $clog2(MAXLIM + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             run;
    logic             last;
    logic             fire;

    // Decode the timeout length and the terminal condition.
    always_comb begin
        limit = CNT_W'(BASE) + CNT_W'(STEP) * CNT_W'(tc);
        run   = enable & ~hold & ~done_o;
        last  = (cnt >= limit - CNT_W'(1));
        fire  = run & tick & last & ~arm;
    end

    // Strobe counter: cleared on arm or when idle, advanced on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || arm || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= last ? '0 : cnt + CNT_W'(1);
        end
    end

    // Expiry strobe and sticky done flag until the gain bit is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expire_o <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            expire_o <= fire;
            if (arm)          done_o <= 1'b0;
            else if (fire)    done_o <= 1'b1;
            else if (!enable) done_o <= 1'b0;
        end
    end

    p_clr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);
    p_clr_needs_timed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> $past(enable));
    p_hold_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0));
    p_arm_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> ((cnt == '0) && !expire_o));
    p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !arm) |=> $stable(cnt));
endmodule

// File: rtl/flk_cur_sel.sv
// Current code selector.
// Drives the boost code while fastlock is enabled, the CP-gain bit is set and
// no timed expiry has happened; otherwise the primary code.
// Assumes: done is only meaningful in timed mode.
module flk_cur_sel #(
    parameter int CODE_W = 3
) (
    input  logic              en,
    input  logic              gain,
    input  logic              timed,
    input  logic              done,
    input  logic [CODE_W-1:0] code_pri,
    input  logic [CODE_W-1:0] code_sec,
    output logic [CODE_W-1:0] code_o
);
    logic boost;

    // Pick the boost or the steady code.
    always_comb begin
        boost  = en & gain & ~(timed & done);
        code_o = boost ? code_sec : code_pri;
    end
endmodule

// File: rtl/fastlock_cp_timer.sv
// Fastlock charge-pump current timer (top).
// Chooses the active charge-pump current code from two programmed settings
// and, in timed mode, clears the CP-gain bit after a strobe-counted timeout.
// Assumes: gain_bit is the register content, updated one edge after gain_set
// or gain_clr; synchronous active-low reset.
module fastlock_cp_timer #(
    parameter int TC_W   = 4,
    parameter int CODE_W = 3,
    parameter int BASE   = 3,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fl_en,
    input  logic              fl_mode,
    input  logic [TC_W-1:0]   tmo_code,
    input  logic [CODE_W-1:0] set_pri,
    input  logic [CODE_W-1:0] set_sec,
    input  logic              gain_bit,
    input  logic              gain_set,
    input  logic              pd_tick,
    input  logic              pwr_dn,
    output logic [CODE_W-1:0] cur_code,
    output logic              gain_clr
);
    import flk_pkg::*;

    logic timed;
    logic tmr_en;
    logic tmr_done;

    // Decode the mode and the timer enable.
    always_comb begin
        timed  = (flk_mode_e'(fl_mode) == MODE_TIMED);
        tmr_en = fl_en & timed & gain_bit;
    end

    flk_timer #(.TC_W(TC_W), .BASE(BASE), .STEP(STEP)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (tmr_en),
        .arm      (gain_set),
        .hold     (pwr_dn),
        .tick     (pd_tick),
        .tc       (tmo_code),
        .expire_o (gain_clr),
        .done_o   (tmr_done)
    );

    flk_cur_sel #(.CODE_W(CODE_W)) u_sel (
        .en       (fl_en),
        .gain     (gain_bit),
        .timed    (timed),
        .done     (tmr_done),
        .code_pri (set_pri),
        .code_sec (set_sec),
        .code_o   (cur_code)
    );

    p_disabled_primary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_en |-> (cur_code == set_pri));
    p_clr_reverts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gain_clr |-> (cur_code == set_pri));
    p_manual_no_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_mode && $past(!fl_mode)) |-> !gain_clr);
endmodule

// File: tb/tb_fastlock_cp_timer.sv
`timescale 1ns/1ps
module tb_fastlock_cp_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fl_en = 1'b0;
    logic       fl_mode = 1'b0;
    logic [3:0] tmo_code = '0;
    logic [2:0] set_pri = 3'd5;
    logic [2:0] set_sec = 3'd2;
    logic       gbit;
    logic       gain_set = 1'b0;
    logic       gain_wr0 = 1'b0;
    logic       pd_tick = 1'b0;
    logic       pwr_dn = 1'b0;
    logic [2:0] cur_code;
    logic       gain_clr;
    int         n_vec = 0;
    int         n_err = 0;

    always #10 clk = ~clk;

    fastlock_cp_timer dut (
        .clk(clk), .rst_n(rst_n), .fl_en(fl_en), .fl_mode(fl_mode),
        .tmo_code(tmo_code), .set_pri(set_pri), .set_sec(set_sec),
        .gain_bit(gbit), .gain_set(gain_set), .pd_tick(pd_tick),
        .pwr_dn(pwr_dn), .cur_code(cur_code), .gain_clr(gain_clr)
    );

    // Model of the external CP-gain register bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        gbit <= 1'b0;
        else if (gain_set) gbit <= 1'b1;
        else if (gain_wr0) gbit <= 1'b0;
        else if (gain_clr) gbit <= 1'b0;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic arm();
        @(negedge clk) gain_set = 1'b1;
        @(negedge clk) gain_set = 1'b0;
    endtask

    task automatic wr0();
        @(negedge clk) gain_wr0 = 1'b1;
        @(negedge clk) gain_wr0 = 1'b0;
    endtask

    // One strobe; returns at the negedge right after the edge that takes it.
    task automatic do_tick();
        @(negedge clk) pd_tick = 1'b1;
        @(negedge clk) pd_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Run k strobes expecting the boost to stay on with no clear.
    task automatic ticks_no_exit(input int k, input string req);
        for (int i = 0; i < k; i++) begin
            do_tick();
            chk(req, cur_code, set_sec);
            chk(req, gain_clr, 0);
            idle(i % 3);
        end
    endtask

    // Final strobe of a timeout: clear pulse and revert, then pulse ends.
    task automatic expect_exit(input string req);
        do_tick();
        chk(req, gain_clr, 1);
        chk(req, cur_code, set_pri);
        @(negedge clk);
        chk("R9", gain_clr, 0);
        chk(req, cur_code, set_pri);
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog: got 0 expected 1 (run did not end)");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        fl_en = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", cur_code, 5);
        chk("R1", gain_clr, 0);

        // R2/R3: all code pairs with enable low then high, CP-gain bit set
        fl_mode = 1'b0;
        fl_en   = 1'b0;
        arm();
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                set_pri = 3'(a);
                set_sec = 3'(b);
                fl_en   = 1'b0;
                #1 chk("R2", cur_code, a);
                fl_en   = 1'b1;
                #1 chk("R3", cur_code, b);
                @(negedge clk);
            end
        end
        set_pri = 3'd1;
        set_sec = 3'd6;

        // R4: manual mode never times out; software write of 0 exits
        ticks_no_exit(80, "R4");
        wr0();
        chk("R4", cur_code, 1);
        chk("R4", gain_clr, 0);

        // R2/R9: timed mode with enable low never clears, stays primary
        fl_en   = 1'b0;
        fl_mode = 1'b1;
        tmo_code = 4'd0;
        arm();
        for (int i = 0; i < 10; i++) begin
            do_tick();
            chk("R2", cur_code, 1);
            chk("R9", gain_clr, 0);
        end
        wr0();
        fl_en = 1'b1;

        // R5/R6: sweep every timeout code with mixed idle gaps
        for (int tc = 0; tc < 16; tc++) begin
            tmo_code = 4'(tc);
            set_pri  = 3'(tc % 8);
            set_sec  = 3'((tc + 3) % 8);
            arm();
            chk("R3", cur_code, (tc + 3) % 8);
            ticks_no_exit(3 + 4 * tc - 1, "R5");
            expect_exit("R5");
            idle(2);
        end
        set_pri = 3'd4;
        set_sec = 3'd7;

        // R7: rewrite mid-timeout restarts from zero (code 2 -> 11 strobes)
        tmo_code = 4'd2;
        arm();
        ticks_no_exit(6, "R7");
        arm();
        ticks_no_exit(10, "R7");
        expect_exit("R7");

        // R8: power-down mid-timeout reloads the counter (code 1 -> 7)
        tmo_code = 4'd1;
        arm();
        ticks_no_exit(4, "R8");
        pwr_dn = 1'b1;
        ticks_no_exit(9, "R8");
        pwr_dn = 1'b0;
        ticks_no_exit(6, "R8");
        expect_exit("R8");

        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule